// File: doc/BRIEF.md
# Prioritised Memory Protection Region Checker

This block decides, for every data access, whether the access may proceed. It holds a bank of eight protection regions. Each region has an enable, a base address, a power-of-two size, a three-bit permission code and a two-bit attribute field. Bit 0 of the attribute field marks the region as cacheable and bit 1 marks it as bufferable. All regions compare the request address in parallel. Among the enabled regions that match, the one with the highest index wins. Its permission code alone decides between grant and abort, and its attributes go out with a granted result. An address that no enabled region claims aborts. Region 0 can be sized to cover the whole 4GB space, which makes it a background default.

Requests use a valid/ready handshake. A request is accepted in a cycle where both `req_valid` and `req_ready` are high. The result is registered and shows up on the response side one clock after acceptance. The response stays valid and unchanged until it is taken with `rsp_ready`. The block holds only one result. `req_ready` is therefore low exactly while a response is waiting and `rsp_ready` is low, so back-pressure from the response side stalls the request side with no loss. Regions are programmed through a plain write port, one whole region per write. No fault status or fault address is kept: an abort is reported only through `rsp_abort`.

Top module: `prot_region_checker`

## Requirements
- R1: After reset, `rsp_valid` is low, `req_ready` is high, and all regions are disabled, so every access aborts until a region is programmed.
- R2: An accepted request produces its result with `rsp_valid` high on the following clock. While `rsp_valid` is high and `rsp_ready` is low, the result is held steady and `req_ready` is low. When the result is consumed, a new request can be accepted in the same cycle.
- R3: The size field gives log2 of the region size in bytes and is clamped to the range 12 to 32. An enabled region matches when every address bit at or above that log2 position equals the same bit of its base. A disabled region never matches.
- R4: An address that matches no enabled region aborts, with `rsp_region` = 0 and `rsp_attr` = 0.
- R5: When several enabled regions match, the highest-numbered one wins. `rsp_region` reports it, and only its permission code is applied.
- R6: Permission codes work as follows. 3'b000 denies everything. 3'b001 allows privileged access only. 3'b010 gives privileged read/write and user read-only, so a user write aborts. 3'b011 allows all access. 3'b100 to 3'b111 deny everything.
- R7: On a grant, `rsp_attr` carries the winning region's attribute field. On any abort, `rsp_attr` is 0.
- R8: A write through the configuration port sets all fields of the region named by `cfg_idx`. The new settings apply to requests accepted in later cycles. A request accepted in the same cycle as the write is judged with the earlier settings.
- R9: Region 0 with size 32 acts as a background. Any address that no higher region claims takes region 0's permission and attributes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write one region's settings |
| cfg_idx | input | 3 | Region written |
| cfg_en | input | 1 | Region enable |
| cfg_base | input | 32 | Region base address |
| cfg_size_log2 | input | 6 | log2 of region size, clamped to 12..32 |
| cfg_ap | input | 3 | Permission code |
| cfg_attr | input | 2 | Attributes: bit 0 cacheable, bit 1 bufferable |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 32 | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = privileged mode, 0 = user mode |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken |
| rsp_abort | output | 1 | Access aborted |
| rsp_attr | output | 2 | Winning region's attributes on a grant, else 0 |
| rsp_region | output | 3 | Winning region index, 0 when nothing matched |

## Verification
Two events can fall in the same cycle: a configuration write and the acceptance of a request. The bench provokes this by driving `cfg_we` and `req_valid` on the same clock edge. The write re-enables a region that would turn the request from abort into grant. The bench expects the old decision for that request and the new one for the next request. A second overlap occurs when a waiting result is consumed in the same cycle that a new request is accepted. The bench holds a result under back-pressure, checks that it does not change, and then releases it with a different request already pending. It expects the pending request's result on the very next clock.

// File: rtl/prot_pkg.sv
package prot_pkg;
  localparam logic [2:0] AP_DENY      = 3'b000;
  localparam logic [2:0] AP_PRIV_ONLY = 3'b001;
  localparam logic [2:0] AP_USER_RO   = 3'b010;
  localparam logic [2:0] AP_ALL       = 3'b011;

  typedef struct packed {
    logic       abort;
    logic [1:0] attr;
    logic [2:0] region;
  } prot_result_t;
endpackage

// File: rtl/prot_region_slot.sv
module prot_region_slot #(
  parameter int ADDR_W   = 32,
  parameter int SIZE_W   = 6,
  parameter int ATTR_W   = 2,
  parameter int MIN_LOG2 = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic              wr_en_bit,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [SIZE_W-1:0] wr_size,
  input  logic [2:0]        wr_ap,
  input  logic [ATTR_W-1:0] wr_attr,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              hit,
  output logic [2:0]        ap,
  output logic [ATTR_W-1:0] attr
);
  localparam logic [SIZE_W-1:0] LO = SIZE_W'(MIN_LOG2);
  localparam logic [SIZE_W-1:0] HI = SIZE_W'(ADDR_W);

  logic              en_q;
  logic [ADDR_W-1:0] base_q;
  logic [SIZE_W-1:0] size_q;
  logic [SIZE_W-1:0] size_clamped;
  logic [ADDR_W-1:0] keep;
  logic [ADDR_W-1:0] diff;

  always_comb begin
    if (wr_size < LO)      size_clamped = LO;
    else if (wr_size > HI) size_clamped = HI;
    else                   size_clamped = wr_size;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      base_q <= '0;
      size_q <= HI;
      ap     <= 3'b000;
      attr   <= '0;
    end else if (wr_sel) begin
      en_q   <= wr_en_bit;
      base_q <= wr_base;
      size_q <= size_clamped;
      ap     <= wr_ap;
      attr   <= wr_attr;
    end
  end

  always_comb begin
    for (int i = 0; i < ADDR_W; i++)
      keep[i] = (i >= int'(size_q));
    diff = (look_addr ^ base_q) & keep;
    hit  = en_q && (diff == '0);
  end
endmodule

// File: rtl/prot_prio_pick.sv
module prot_prio_pick #(
  parameter int N = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     hits,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hits[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/prot_perm_decode.sv
module prot_perm_decode
  import prot_pkg::*;
(
  input  logic [2:0] ap,
  input  logic       priv,
  input  logic       write,
  output logic       allow
);
  always_comb begin
    case (ap)
      AP_PRIV_ONLY: allow = priv;
      AP_USER_RO:   allow = priv || !write;
      AP_ALL:       allow = 1'b1;
      default:      allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/prot_region_checker.sv
module prot_region_checker #(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32,
  parameter int SIZE_W      = 6,
  parameter int ATTR_W      = 2,
  parameter int MIN_LOG2    = 12,
  localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_en,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [SIZE_W-1:0] cfg_size_log2,
  input  logic [2:0]        cfg_ap,
  input  logic [ATTR_W-1:0] cfg_attr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_priv,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_abort,
  output logic [ATTR_W-1:0] rsp_attr,
  output logic [IDX_W-1:0]  rsp_region
);
  logic [NUM_REGIONS-1:0] hits;
  logic [2:0]             ap_arr   [NUM_REGIONS];
  logic [ATTR_W-1:0]      attr_arr [NUM_REGIONS];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_slot
    prot_region_slot #(
      .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .ATTR_W(ATTR_W), .MIN_LOG2(MIN_LOG2)
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_sel    (cfg_we && (cfg_idx == IDX_W'(g))),
      .wr_en_bit (cfg_en),
      .wr_base   (cfg_base),
      .wr_size   (cfg_size_log2),
      .wr_ap     (cfg_ap),
      .wr_attr   (cfg_attr),
      .look_addr (req_addr),
      .hit       (hits[g]),
      .ap        (ap_arr[g]),
      .attr      (attr_arr[g])
    );
  end

  logic             any_hit;
  logic [IDX_W-1:0] win_idx;
  logic             allow;

  prot_prio_pick #(.N(NUM_REGIONS)) u_pick (
    .hits (hits),
    .any  (any_hit),
    .idx  (win_idx)
  );

  prot_perm_decode u_perm (
    .ap    (ap_arr[win_idx]),
    .priv  (req_priv),
    .write (req_write),
    .allow (allow)
  );

  logic grant_d;
  assign grant_d   = any_hit && allow;
  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_abort  <= 1'b0;
      rsp_attr   <= '0;
      rsp_region <= '0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_abort  <= !grant_d;
        rsp_attr   <= grant_d ? attr_arr[win_idx] : '0;
        rsp_region <= win_idx;
      end
    end
  end
endmodule

// File: rtl/prot_region_checker_sva.sv
module prot_region_checker_sva #(
  parameter int ATTR_W = 2,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_abort,
  input logic [ATTR_W-1:0] rsp_attr,
  input logic [IDX_W-1:0]  rsp_region
);
  logic seen_wr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seen_wr <= 1'b0;
    else if (cfg_we) seen_wr <= 1'b1;
  end

  // R2
  accept_gives_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  // R2
  stall_blocks_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  // R2
  held_result_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable({rsp_abort, rsp_attr, rsp_region}));

  // R7
  abort_attr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_abort |-> rsp_attr == '0);

  // R1
  unprogrammed_aborts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !seen_wr |-> rsp_abort);
endmodule

bind prot_region_checker prot_region_checker_sva #(.ATTR_W(ATTR_W), .IDX_W(IDX_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_abort  (rsp_abort),
  .rsp_attr   (rsp_attr),
  .rsp_region (rsp_region)
);

// File: tb/prot_region_checker_test.sv
`timescale 1ns/1ps
module prot_region_checker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic        cfg_en = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [5:0]  cfg_size_log2 = '0;
  logic [2:0]  cfg_ap = '0;
  logic [1:0]  cfg_attr = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_priv = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_abort;
  logic [1:0]  rsp_attr;
  logic [2:0]  rsp_region;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  prot_region_checker uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
    .cfg_base(cfg_base), .cfg_size_log2(cfg_size_log2), .cfg_ap(cfg_ap), .cfg_attr(cfg_attr),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .req_priv(req_priv), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_abort(rsp_abort),
    .rsp_attr(rsp_attr), .rsp_region(rsp_region)
  );

  // {addr, write, priv, abort, region, attr}
  localparam int NV = 13;
  localparam logic [39:0] VEC [NV] = '{
    {32'h0000_3010, 1'b0, 1'b0, 1'b0, 3'd2, 2'b10},
    {32'h0000_3010, 1'b1, 1'b0, 1'b1, 3'd2, 2'b00},
    {32'h0000_3010, 1'b1, 1'b1, 1'b0, 3'd2, 2'b10},
    {32'h0000_1000, 1'b0, 1'b0, 1'b1, 3'd1, 2'b00},
    {32'h0000_1000, 1'b1, 1'b1, 1'b0, 3'd1, 2'b01},
    {32'h0001_0010, 1'b0, 1'b1, 1'b1, 3'd3, 2'b00},
    {32'h8000_0100, 1'b0, 1'b0, 1'b1, 3'd7, 2'b00},
    {32'h8000_0100, 1'b0, 1'b1, 1'b0, 3'd7, 2'b10},
    {32'h8000_2000, 1'b1, 1'b0, 1'b0, 3'd5, 2'b11},
    {32'h800F_FFFC, 1'b0, 1'b0, 1'b0, 3'd5, 2'b11},
    {32'h8010_0000, 1'b0, 1'b1, 1'b1, 3'd0, 2'b00},
    {32'hF000_0004, 1'b0, 1'b1, 1'b1, 3'd6, 2'b00},
    {32'h0000_4000, 1'b0, 1'b1, 1'b1, 3'd0, 2'b00}
  };

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got abort/region/attr %b expected %b", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [2:0] idx, input logic en, input logic [31:0] base,
                         input logic [5:0] sz, input logic [2:0] ap, input logic [1:0] at);
    cfg_we = 1'b1; cfg_idx = idx; cfg_en = en; cfg_base = base;
    cfg_size_log2 = sz; cfg_ap = ap; cfg_attr = at;
  endtask

  task automatic write_region(input logic [2:0] idx, input logic en, input logic [31:0] base,
                              input logic [5:0] sz, input logic [2:0] ap, input logic [1:0] at);
    @(negedge clk);
    set_cfg(idx, en, base, sz, ap, at);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input string req, input logic [31:0] a, input logic w, input logic p,
                        input logic ab, input logic [2:0] rg, input logic [1:0] at);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_priv = p;
    @(negedge clk);
    req_valid = 1'b0;
    check(req, {rsp_valid, rsp_abort, rsp_region, rsp_attr[0]}, {1'b1, ab, rg, at[0]});
    check(req, {4'b0, rsp_attr}, {4'b0, at});
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {4'b0, rsp_valid, req_ready}, {4'b0, 1'b0, 1'b1});
    rst_n = 1'b1;
    // R1: nothing programmed, abort with region 0
    access("R1", 32'h0000_3010, 1'b0, 1'b1, 1'b1, 3'd0, 2'b00);

    // R3 region map; size field is log2 bytes
    write_region(3'd1, 1'b1, 32'h0000_0000, 6'd14, 3'b001, 2'b01);
    write_region(3'd2, 1'b1, 32'h0000_3000, 6'd12, 3'b010, 2'b10);
    write_region(3'd3, 1'b1, 32'h0001_0000, 6'd16, 3'b000, 2'b01);
    write_region(3'd5, 1'b1, 32'h8000_0000, 6'd20, 3'b011, 2'b11);
    write_region(3'd6, 1'b1, 32'hF000_0000, 6'd16, 3'b101, 2'b11);
    write_region(3'd7, 1'b1, 32'h8000_0000, 6'd3,  3'b001, 2'b10); // clamps to 12

    // R3 R4 R5 R6 R7: table walk
    for (int k = 0; k < NV; k++) begin
      access($sformatf("R3/R4/R5/R6/R7 vec%0d", k), VEC[k][39:8], VEC[k][7], VEC[k][6],
             VEC[k][5], VEC[k][4:2], VEC[k][1:0]);
    end

    // R9: background region 0 over the full space
    write_region(3'd0, 1'b1, 32'h0000_0000, 6'd32, 3'b011, 2'b01);
    access("R9", 32'h0000_4000, 1'b0, 1'b0, 1'b0, 3'd0, 2'b01);
    access("R9", 32'h8010_0000, 1'b1, 1'b0, 1'b0, 3'd0, 2'b01);
    access("R9 R5", 32'h0000_3010, 1'b1, 1'b0, 1'b1, 3'd2, 2'b00);

    // R3: disabled region no longer matches
    write_region(3'd2, 1'b0, 32'h0000_3000, 6'd12, 3'b010, 2'b10);
    access("R3", 32'h0000_3010, 1'b0, 1'b0, 1'b1, 3'd1, 2'b00);

    // R8: write and request in the same cycle
    @(negedge clk);
    set_cfg(3'd2, 1'b1, 32'h0000_3000, 6'd12, 3'b011, 2'b11);
    req_valid = 1'b1; req_addr = 32'h0000_3010; req_write = 1'b1; req_priv = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    check("R8 old", {3'b0, rsp_valid, rsp_abort, rsp_region[0]}, {3'b0, 1'b1, 1'b1, 1'b1});
    access("R8 new", 32'h0000_3010, 1'b1, 1'b0, 1'b0, 3'd2, 2'b11);

    // R2: back-pressure hold, then release with a pending request
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_addr = 32'h0000_1000; req_write = 1'b0; req_priv = 1'b0;
    @(negedge clk);
    req_addr = 32'h0000_3010;
    check("R2 held", {rsp_valid, req_ready, rsp_abort, rsp_region}, {1'b1, 1'b0, 1'b1, 3'd1});
    @(negedge clk);
    check("R2 stable", {rsp_valid, req_ready, rsp_abort, rsp_region}, {1'b1, 1'b0, 1'b1, 3'd1});
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 next", {rsp_valid, rsp_abort, rsp_region, rsp_attr[0]}, {1'b1, 1'b0, 3'd2, 1'b1});
    @(negedge clk);
    check("R2 drain", {5'b0, rsp_valid}, 6'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule